// File: doc/BRIEF.md
# Interleaved Manchester Bit-Stream Encoder

This block takes the one-bit outputs of two pulse-density modulator channels and sends them on one serial line, together with a synchronization stream. Every frame is three coded bits long. The first bit is a sync bit that alternates from frame to frame. The second bit comes from channel 0 and the third from channel 1. Each bit is Manchester-coded and lasts four system clocks. A receiver can therefore recover both the bit timing and the frame boundary from this single line, even when the line is capacitively coupled.

A power-up controller drives `enable`. While `enable` is low, the line is parked low and the frame state is cleared. When `enable` rises, the first frame begins on the next clock edge. At the start of every frame the block samples both channel bits into a holding register. In the same cycle it pulses `sample_req` for one clock, which tells the modulators that their bits have been taken. The output level comes straight from a flip-flop.

Top module: `mnch_frame_encoder`

## Requirements
- R1: While `rst_n` is low, `line_out` and `sample_req` are 0. After any clock edge at which `enable` is sampled low, both are also 0 in the following cycle.
- R2: Each coded bit lasts exactly 4 clocks, made of two halves of 2 clocks each. The level stays constant within a half and always changes between the second and third clock of the bit.
- R3: A bit value of 1 is sent low for clocks 0–1 and high for clocks 2–3. A bit value of 0 is sent high for clocks 0–1 and low for clocks 2–3.
- R4: A frame is 12 clocks and carries three bits in a fixed order: slot 0 is the sync bit, slot 1 is `chan_bit[0]` and slot 2 is `chan_bit[1]`.
- R5: The sync bit of the first frame after encoding starts is 0. Each later frame carries the inverse of the previous frame's sync bit.
- R6: `sample_req` is high for exactly one cycle per frame: the first clock of slot 0. It is low in all other cycles.
- R7: The channel bits are sampled at the clock edge that starts a frame. Changes to `chan_bit` at any other time have no effect on that frame's coded bits.
- R8: At the first clock edge at which `enable` is sampled high, encoding starts. In the next cycle `sample_req` is 1 and `line_out` is 1, which is the first half of sync bit 0.
- R9: If `enable` drops or reset is applied part-way through a frame, the frame is abandoned. When encoding restarts, it begins with a new frame whose sync bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Encoding enable from the power-up controller |
| chan_bit | input | NUM_CH (2) | Current modulator output bits, one per channel |
| sample_req | output | 1 | One-cycle strobe marking channel-bit capture at frame start |
| line_out | output | 1 | Registered Manchester-coded serial output |

## Verification
Three internal states can go wrong: the half-bit phase counter, the slot counter and the sync toggle. A fault in the phase counter moves or removes the mid-bit transition, and this shows on `line_out` within one bit time, at most 4 clocks. A fault in the slot counter or the sync toggle breaks the frame pattern. It shows within one 12-clock frame as a wrong decoded bit or as `sample_req` firing outside slot 0. A capture fault only appears when the channel inputs change during a frame, so the stimulus changes them on every clock.

// File: rtl/mnch_pkg.sv
package mnch_pkg;

   // Manchester level for one half of a bit: a 1 is low then high,
   // a 0 is high then low.
   function automatic logic coded_level(input logic data_bit, input logic first_half);
      return data_bit ^ first_half;
   endfunction

endpackage

// File: rtl/mnch_slot_timer.sv
module mnch_slot_timer #(
   parameter int BIT_CLKS = 4,
   parameter int SLOTS    = 3,
   parameter int PH_W     = 2,
   parameter int SL_W     = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   output logic            active_q,
   output logic [PH_W-1:0] phase_q,
   output logic [SL_W-1:0] slot_q,
   output logic [PH_W-1:0] nxt_phase,
   output logic [SL_W-1:0] nxt_slot,
   output logic            frame_load,
   output logic            frame_wrap
);

   localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CLKS - 1);
   localparam logic [SL_W-1:0] SL_LAST = SL_W'(SLOTS - 1);

   logic last_ph;
   logic last_sl;

   assign last_ph    = (phase_q == PH_LAST);
   assign last_sl    = (slot_q == SL_LAST);
   assign frame_wrap = enable & active_q & last_ph & last_sl;
   assign frame_load = enable & (~active_q | (last_ph & last_sl));

   always_comb begin
      nxt_phase = '0;
      nxt_slot  = '0;
      if (enable && active_q) begin
         if (last_ph) begin
            nxt_phase = '0;
            nxt_slot  = last_sl ? '0 : slot_q + SL_W'(1);
         end else begin
            nxt_phase = phase_q + PH_W'(1);
            nxt_slot  = slot_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         phase_q  <= '0;
         slot_q   <= '0;
      end else begin
         active_q <= enable;
         phase_q  <= nxt_phase;
         slot_q   <= nxt_slot;
      end
   end

   // R4: the slot index only moves on the last clock of a bit
   a_r4_slot_steps_on_bit_end: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && enable && !last_ph) |=> $stable(slot_q));

endmodule

// File: rtl/mnch_frame_mux.sv
module mnch_frame_mux #(
   parameter int NUM_CH = 2,
   parameter int SL_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              frame_load,
   input  logic              frame_wrap,
   input  logic [NUM_CH-1:0] chan_bit,
   input  logic [SL_W-1:0]   nxt_slot,
   output logic              nxt_bit,
   output logic              sync_q
);

   logic              nxt_sync;
   logic [NUM_CH-1:0] hold_q;
   logic [NUM_CH-1:0] nxt_hold;

   always_comb begin
      if (!enable)         nxt_sync = 1'b0;
      else if (frame_wrap) nxt_sync = ~sync_q;
      else if (frame_load) nxt_sync = 1'b0;
      else                 nxt_sync = sync_q;
   end

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_hold
         assign nxt_hold[g] = frame_load ? chan_bit[g] : hold_q[g];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hold_q[g] <= 1'b0;
            else        hold_q[g] <= nxt_hold[g];
         end
      end
   endgenerate

   always_comb begin
      nxt_bit = nxt_sync;
      for (int i = 0; i < NUM_CH; i++) begin
         if (nxt_slot == SL_W'(i + 1)) nxt_bit = nxt_hold[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 1'b0;
      else        sync_q <= nxt_sync;
   end

   // R5: sync toggles across a frame boundary
   a_r5_sync_flips: assert property (@(posedge clk) disable iff (!rst_n)
      frame_wrap |=> (sync_q != $past(sync_q)));
   // R5 / R9: a fresh start always carries sync 0
   a_r9_restart_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_load && !frame_wrap) |=> !sync_q);
   // R7: held channel bits only change at a frame start
   a_r7_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_load |=> $stable(hold_q));

endmodule

// File: rtl/mnch_line_coder.sv
module mnch_line_coder #(
   parameter int PH_W      = 2,
   parameter int HALF_CLKS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            nxt_bit,
   input  logic [PH_W-1:0] nxt_phase,
   input  logic            frame_load,
   output logic            line_out,
   output logic            sample_req
);
   import mnch_pkg::*;

   localparam logic [PH_W-1:0] PH_MID = PH_W'(HALF_CLKS);

   logic first_half;

   assign first_half = (nxt_phase < PH_MID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_out   <= 1'b0;
         sample_req <= 1'b0;
      end else begin
         line_out   <= enable ? coded_level(nxt_bit, first_half) : 1'b0;
         sample_req <= frame_load;
      end
   end

   // R1: disabled means a low line on the next cycle
   a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!line_out && !sample_req));

endmodule

// File: rtl/mnch_frame_encoder.sv
module mnch_frame_encoder #(
   parameter int NUM_CH    = 2,
   parameter int HALF_CLKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [NUM_CH-1:0] chan_bit,
   output logic              sample_req,
   output logic              line_out
);

   localparam int BIT_CLKS = 2 * HALF_CLKS;
   localparam int SLOTS    = NUM_CH + 1;
   localparam int PH_W     = $clog2(BIT_CLKS);
   localparam int SL_W     = $clog2(SLOTS);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (HALF_CLKS < 1) begin : g_bad_half
         $error("HALF_CLKS must be at least 1");
      end
   endgenerate

   logic            active_q;
   logic [PH_W-1:0] phase_q;
   logic [SL_W-1:0] slot_q;
   logic [PH_W-1:0] nxt_phase;
   logic [SL_W-1:0] nxt_slot;
   logic            frame_load;
   logic            frame_wrap;
   logic            nxt_bit;
   logic            sync_q;

   mnch_slot_timer #(
      .BIT_CLKS(BIT_CLKS), .SLOTS(SLOTS), .PH_W(PH_W), .SL_W(SL_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .active_q(active_q), .phase_q(phase_q), .slot_q(slot_q),
      .nxt_phase(nxt_phase), .nxt_slot(nxt_slot),
      .frame_load(frame_load), .frame_wrap(frame_wrap)
   );

   mnch_frame_mux #(
      .NUM_CH(NUM_CH), .SL_W(SL_W)
   ) u_mux (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .frame_load(frame_load), .frame_wrap(frame_wrap),
      .chan_bit(chan_bit), .nxt_slot(nxt_slot),
      .nxt_bit(nxt_bit), .sync_q(sync_q)
   );

   mnch_line_coder #(
      .PH_W(PH_W), .HALF_CLKS(HALF_CLKS)
   ) u_coder (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .nxt_bit(nxt_bit), .nxt_phase(nxt_phase), .frame_load(frame_load),
      .line_out(line_out), .sample_req(sample_req)
   );

   // R2: the level flips at the middle of every bit
   a_r2_mid_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q) && phase_q == PH_W'(HALF_CLKS))
         |-> (line_out != $past(line_out)));
   // R2: the level holds inside each half
   a_r2_half_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q) && phase_q != '0 && phase_q != PH_W'(HALF_CLKS))
         |-> $stable(line_out));
   // R6: the strobe only appears on the first clock of slot 0
   a_r6_req_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      sample_req |-> (active_q && phase_q == '0 && slot_q == '0));
   // R8: the first enabled edge gives strobe and high line
   a_r8_start_high: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !active_q) |=> (line_out && sample_req));

endmodule

// File: tb/sim_mnch_frame_encoder.sv
module sim_mnch_frame_encoder;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 2;
   localparam int BITC       = 4;
   localparam int FRAME      = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [1:0] chan = 2'b00;
   logic       line_out;
   logic       sample_req;

   always #(CLK_PERIOD/2) clk = ~clk;

   mnch_frame_encoder #(.NUM_CH(2), .HALF_CLKS(HALF)) u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .chan_bit(chan),
      .sample_req(sample_req), .line_out(line_out)
   );

   int tests = 0;
   int fails = 0;

   // behavioural reference: position inside the frame, -1 when idle
   int         pos = -1;
   int         frames = 0;
   logic       m_sync = 1'b0;
   logic [1:0] m_cap = 2'b00;
   logic       eb = 1'b0;
   logic       exp_line = 1'b0;
   logic       exp_req = 1'b0;
   logic       started_now = 1'b0;
   logic       chg_in_frame = 1'b0;
   logic       had_restart = 1'b0;
   logic       lvl1 = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n || !enable) begin
         pos = -1; exp_line = 1'b0; exp_req = 1'b0; started_now = 1'b0;
      end else begin
         started_now = (pos < 0);
         pos = started_now ? 0 : (pos + 1) % FRAME;
         if (pos == 0) begin
            m_sync = started_now ? 1'b0 : ~m_sync;
            m_cap = chan;
            chg_in_frame = 1'b0;
            frames = started_now ? 0 : frames + 1;
         end
         eb = (pos / BITC == 0) ? m_sync : m_cap[pos / BITC - 1];
         exp_line = eb ^ ((pos % BITC) < HALF);
         exp_req = (pos == 0);
      end
   end

   task automatic chk(input logic ok, input string tag, input logic act, input logic exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      string tag;
      if (pos < 0)                 tag = "R1";
      else if (pos % BITC == HALF) tag = "R2";
      else if (pos / BITC == 0)    tag = "R5";
      else                         tag = "R3";
      chk(line_out === exp_line, tag, line_out, exp_line);
      chk(sample_req === exp_req, (pos < 0) ? "R1" : "R6", sample_req, exp_req);
      if (pos == 0 && started_now)
         chk(line_out === 1'b1 && sample_req === 1'b1, "R8", line_out, 1'b1);
      if (pos >= 0 && pos % BITC == 1) lvl1 = line_out;
      if (pos >= 0 && pos % BITC == 3) begin
         if (pos / BITC == 0)
            tag = (frames == 0 && had_restart) ? "R9" : "R5";
         else
            tag = chg_in_frame ? "R7" : "R4";
         chk(lvl1 !== line_out && line_out === eb, tag, line_out, eb);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic set_chan(input logic [1:0] v);
      if (v != chan && pos >= 0) chg_in_frame = 1'b1;
      chan = v;
   endtask

   function automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      tests++; fails++;
      $display("FAIL watchdog: got hang expected finish");
      void'(summary());
      $finish;
   end

   initial begin
      logic [7:0] lfsr;
      lfsr = 8'hA5;
      step(4);
      rst_n = 1'b1;                 // R1 with enable low
      step(3);
      enable = 1'b1;                // R8 start
      set_chan(2'b10); step(2 * FRAME);
      set_chan(2'b01); step(2 * FRAME);
      set_chan(2'b11); step(FRAME);
      set_chan(2'b00); step(FRAME);
      for (int i = 0; i < 100; i++) begin   // R7: chan changes every clock
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         set_chan(lfsr[1:0]);
         step(1);
      end
      step(5);
      enable = 1'b0;                // R9: abandon mid-frame
      had_restart = 1'b1;
      step(5);
      enable = 1'b1;
      set_chan(2'b01); step(3 * FRAME + 5);
      rst_n = 1'b0;                 // R9: async reset mid-frame
      step(3);
      rst_n = 1'b1;
      set_chan(2'b10); step(3 * FRAME);
      enable = 1'b0;
      step(3);
      void'(summary());
      $finish;
   end

endmodule